// File: doc/BRIEF.md
# EDO DRAM Strobe Sequencer

This block sits between a synchronous host port and an asynchronous extended-data-out DRAM. It takes one request at a time and plays it out as a timed sequence on the row strobe, the column strobe, the write enable, the output enable and a shared row/column address bus. The request is a read, an early write, an output-enable-controlled late write, or a read-modify-write. Each phase lasts a whole number of clock cycles, and each of those numbers is a parameter. The number of cycles and the order of edges therefore follow from the clock period that the integrator picks.

The write sequences differ in where the write-enable edge falls relative to the column strobe and the output enable. The write strobe can lead the column strobe, so that the memory never turns its output on. It can trail the column strobe while the output enable stays high. Or it can follow a completed read, after the output enable has been raised for the memory's turn-off time. The host-side data driver is switched on only in write phases that the memory cannot be driving. A build-time option covers boards whose output enable is wired low. In that option, sequences that need the output enable are refused, and after a read the write strobe is pulsed while the column strobe is high so that the memory outputs float.

Top module: `edo_seq`

## Requirements
- R1: While reset is held and after it is released, mem_ras_n, mem_cas_n, mem_we_n and mem_oe_n are high, mem_dq_drive is low and req_ready is high.
- R2: The row address (req_addr[7:4] in the default build) stays on mem_addr for at least T_ASR cycles before mem_ras_n falls and for exactly T_RAH cycles from the fall. The column address (req_addr[3:0]) stays for at least T_ASC cycles before mem_cas_n falls.
- R3: mem_cas_n is high in every cycle in which mem_ras_n falls, so each access starts a fresh memory cycle. mem_cas_n falls only while mem_ras_n is low.
- R4: Request kind 1 (early write) drives mem_we_n low exactly T_WCS cycles before mem_cas_n falls, with the host data already on the bus. The addressed cell then holds req_wdata.
- R5: Request kind 2 (late write) drops mem_we_n exactly T_CWD cycles after mem_cas_n falls, with mem_oe_n high, and the addressed cell then holds req_wdata.
- R6: Request kind 3 (read-modify-write) returns the cell's old contents on rsp_rdata. mem_we_n falls exactly T_CAC+T_OD cycles after mem_cas_n, with mem_oe_n high, and the cell then holds req_wdata.
- R7: Request kind 0 (read) returns the addressed cell on rsp_rdata. mem_we_n stays high throughout the row cycle, so the read ends with both strobes raised.
- R8: mem_dq_drive is high only while mem_we_n is low, and (unless OE_TIED) only while mem_oe_n is high. The host and the memory never drive the data bus in the same cycle.
- R9: With OE_TIED=1, mem_oe_n is always low. A kind 2 or kind 3 request gets a single response with rsp_err high and causes no mem_ras_n fall.
- R10: With OE_TIED=1, every read is followed by a mem_we_n low pulse while both mem_cas_n and mem_ras_n are high.
- R11: req_ready is high only when the block is idle with all strobes high. Each accepted request yields exactly one rsp_valid pulse lasting one cycle, in the first precharge cycle, or in the cycle after acceptance for a refused request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| req_kind | input | 2 | 0 read, 1 early write, 2 late write, 3 read-modify-write |
| req_addr | input | ROW_W+COL_W | Row in the upper bits, column in the lower bits |
| req_wdata | input | DQ_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request refused (with rsp_valid) |
| rsp_rdata | output | DQ_W | Read data for kinds 0 and 3 |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | AW | Multiplexed row/column address |
| mem_dq_out | output | DQ_W | Data toward the memory |
| mem_dq_drive | output | 1 | Enable of the host data driver |
| mem_dq_in | input | DQ_W | Data from the memory |

## Verification
The hardest situation to reach from the ports is the read-modify-write turnaround. There, the memory must have driven valid old data, lost its output enable and had its bus released before the host driver turns on. Both mistakes only show up if the bus owner is tracked edge by edge. The bench therefore attaches a behavioural memory that decides from the strobe edges alone whether it drives the bus. That memory counts contention, latches the write at the later of the column-strobe and write-strobe falls, and measures the edge spacings. Every address then goes through all four kinds, and a read-back separates the old value from the new.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;

  typedef enum logic [1:0] {
    KIND_READ   = 2'd0,
    KIND_EWRITE = 2'd1,
    KIND_LWRITE = 2'd2,
    KIND_RMW    = 2'd3
  } kind_e;

  typedef enum logic [3:0] {
    PH_IDLE, PH_REJ, PH_ROW, PH_RAS, PH_COL, PH_WSU,
    PH_EWR, PH_RD, PH_LCAS, PH_OFF, PH_LWE, PH_PRE
  } phase_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic oe_n;
    logic col_sel;
    logic drive;
  } strobe_t;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic kind_needs_oe(kind_e k);
    return (k == KIND_LWRITE) || (k == KIND_RMW);
  endfunction

  // Strobe levels for each phase; all inactive unless listed.
  function automatic strobe_t strobe_of(phase_e p, kind_e k, logic oe_tied);
    strobe_t s;
    s = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
          col_sel: 1'b0, drive: 1'b0};
    case (p)
      PH_RAS: s.ras_n = 1'b0;
      PH_COL: begin s.ras_n = 1'b0; s.col_sel = 1'b1; end
      PH_WSU: begin
        s.ras_n = 1'b0; s.col_sel = 1'b1; s.we_n = 1'b0; s.drive = 1'b1;
      end
      PH_EWR, PH_LWE: begin
        s.ras_n = 1'b0; s.cas_n = 1'b0; s.col_sel = 1'b1;
        s.we_n  = 1'b0; s.drive = 1'b1;
      end
      PH_RD: begin
        s.ras_n = 1'b0; s.cas_n = 1'b0; s.col_sel = 1'b1; s.oe_n = 1'b0;
      end
      PH_LCAS, PH_OFF: begin
        s.ras_n = 1'b0; s.cas_n = 1'b0; s.col_sel = 1'b1;
      end
      PH_PRE: s.we_n = ~(oe_tied & (k == KIND_READ));
      default: ;
    endcase
    if (oe_tied) s.oe_n = 1'b0;
    return s;
  endfunction

endpackage

// File: rtl/edo_phase_timer.sv
module edo_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign expired = (cnt_q == '0);

  always_comb begin
    cnt_en = load | ~expired;
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/edo_addr_mux.sv
module edo_addr_mux #(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int AW    = 4
) (
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic                   col_sel,
  output logic [AW-1:0]          mux_addr
);

  logic [AW-1:0] row_ext;
  logic [AW-1:0] col_ext;

  generate
    if (ROW_W == AW) begin : g_row_full
      assign row_ext = addr[ROW_W+COL_W-1 -: ROW_W];
    end else begin : g_row_pad
      assign row_ext = {{(AW-ROW_W){1'b0}}, addr[ROW_W+COL_W-1 -: ROW_W]};
    end
    if (COL_W == AW) begin : g_col_full
      assign col_ext = addr[COL_W-1:0];
    end else begin : g_col_pad
      assign col_ext = {{(AW-COL_W){1'b0}}, addr[COL_W-1:0]};
    end
  endgenerate

  assign mux_addr = col_sel ? col_ext : row_ext;

endmodule

// File: rtl/edo_seq_ctrl.sv
module edo_seq_ctrl
  import edo_seq_pkg::*;
#(
  parameter int   T_ASR   = 1,
  parameter int   T_RAH   = 2,
  parameter int   T_ASC   = 1,
  parameter int   T_WCS   = 2,
  parameter int   T_CAS   = 2,
  parameter int   T_CAC   = 3,
  parameter int   T_CWD   = 2,
  parameter int   T_OD    = 2,
  parameter int   T_WP    = 2,
  parameter int   T_RP    = 3,
  parameter logic OE_TIED = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_kind,
  output logic       req_ready,
  output strobe_t    strobe,
  output logic       capture,
  output logic       rsp_valid,
  output logic       rsp_err
);

  localparam int TMAX = max2(max2(max2(T_ASR, T_RAH), max2(T_ASC, T_WCS)),
                             max2(max2(max2(T_CAS, T_CAC), max2(T_CWD, T_OD)),
                                  max2(T_WP, T_RP)));
  localparam int TW = $clog2(TMAX + 1);

  phase_e  phase_q, phase_d;
  kind_e   kind_q, kind_d;
  strobe_t strobe_q, strobe_d;
  logic    rsp_q, rsp_d;
  logic    err_q, err_d;
  logic    accept;
  logic    load;
  logic    expired;
  logic [TW-1:0] load_val;

  function automatic int phase_len(phase_e p);
    case (p)
      PH_ROW:  return T_ASR;
      PH_RAS:  return T_RAH;
      PH_COL:  return T_ASC;
      PH_WSU:  return T_WCS;
      PH_EWR:  return T_CAS;
      PH_RD:   return T_CAC;
      PH_LCAS: return T_CWD;
      PH_OFF:  return T_OD;
      PH_LWE:  return T_WP;
      PH_PRE:  return T_RP;
      default: return 1;
    endcase
  endfunction

  assign req_ready = (phase_q == PH_IDLE);
  assign accept    = req_ready & req_valid;

  always_comb begin
    phase_d = phase_q;
    kind_d  = accept ? kind_e'(req_kind) : kind_q;
    capture = 1'b0;
    case (phase_q)
      PH_IDLE: if (accept) begin
        if (OE_TIED && kind_needs_oe(kind_e'(req_kind))) phase_d = PH_REJ;
        else                                              phase_d = PH_ROW;
      end
      PH_REJ:  phase_d = PH_IDLE;
      PH_ROW:  if (expired) phase_d = PH_RAS;
      PH_RAS:  if (expired) phase_d = PH_COL;
      PH_COL:  if (expired) begin
        case (kind_q)
          KIND_EWRITE: phase_d = PH_WSU;
          KIND_LWRITE: phase_d = PH_LCAS;
          default:     phase_d = PH_RD;
        endcase
      end
      PH_WSU:  if (expired) phase_d = PH_EWR;
      PH_EWR:  if (expired) phase_d = PH_PRE;
      PH_RD:   if (expired) begin
        capture = 1'b1;
        phase_d = (kind_q == KIND_RMW) ? PH_OFF : PH_PRE;
      end
      PH_LCAS: if (expired) phase_d = PH_LWE;
      PH_OFF:  if (expired) phase_d = PH_LWE;
      PH_LWE:  if (expired) phase_d = PH_PRE;
      PH_PRE:  if (expired) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
    load     = (phase_d != phase_q);
    load_val = TW'(phase_len(phase_d) - 1);
    strobe_d = strobe_of(phase_d, kind_d, OE_TIED);
    rsp_d    = ((phase_d == PH_PRE) && (phase_q != PH_PRE)) || (phase_d == PH_REJ);
    err_d    = (phase_d == PH_REJ);
  end

  edo_phase_timer #(.CNT_W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      kind_q   <= KIND_READ;
      strobe_q <= strobe_of(PH_IDLE, KIND_READ, OE_TIED);
      rsp_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      kind_q   <= kind_d;
      strobe_q <= strobe_d;
      rsp_q    <= rsp_d;
      err_q    <= err_d;
    end
  end

  assign strobe    = strobe_q;
  assign rsp_valid = rsp_q;
  assign rsp_err   = err_q;

endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_seq_pkg::*;
#(
  parameter int   ROW_W   = 4,
  parameter int   COL_W   = 4,
  parameter int   DQ_W    = 4,
  parameter int   T_ASR   = 1,
  parameter int   T_RAH   = 2,
  parameter int   T_ASC   = 1,
  parameter int   T_WCS   = 2,
  parameter int   T_CAS   = 2,
  parameter int   T_CAC   = 3,
  parameter int   T_CWD   = 2,
  parameter int   T_OD    = 2,
  parameter int   T_WP    = 2,
  parameter int   T_RP    = 3,
  parameter logic OE_TIED = 1'b0,
  localparam int  AW      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [1:0]             req_kind,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DQ_W-1:0]        req_wdata,
  output logic                   rsp_valid,
  output logic                   rsp_err,
  output logic [DQ_W-1:0]        rsp_rdata,
  output logic                   mem_ras_n,
  output logic                   mem_cas_n,
  output logic                   mem_we_n,
  output logic                   mem_oe_n,
  output logic [AW-1:0]          mem_addr,
  output logic [DQ_W-1:0]        mem_dq_out,
  output logic                   mem_dq_drive,
  input  logic [DQ_W-1:0]        mem_dq_in
);

  strobe_t                strobe;
  logic                   capture;
  logic                   accept;
  logic [ROW_W+COL_W-1:0] addr_q;
  logic [DQ_W-1:0]        wdata_q;
  logic [DQ_W-1:0]        rdata_q;

  edo_seq_ctrl #(
    .T_ASR(T_ASR), .T_RAH(T_RAH), .T_ASC(T_ASC), .T_WCS(T_WCS),
    .T_CAS(T_CAS), .T_CAC(T_CAC), .T_CWD(T_CWD), .T_OD(T_OD),
    .T_WP(T_WP), .T_RP(T_RP), .OE_TIED(OE_TIED)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_ready (req_ready),
    .strobe    (strobe),
    .capture   (capture),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err)
  );

  assign accept = req_valid & req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= mem_dq_in;
  end

  edo_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .AW(AW)) u_mux (
    .addr     (addr_q),
    .col_sel  (strobe.col_sel),
    .mux_addr (mem_addr)
  );

  assign mem_ras_n    = strobe.ras_n;
  assign mem_cas_n    = strobe.cas_n;
  assign mem_we_n     = strobe.we_n;
  assign mem_oe_n     = strobe.oe_n;
  assign mem_dq_drive = strobe.drive;
  assign mem_dq_out   = wdata_q;
  assign rsp_rdata    = rdata_q;

endmodule

// File: rtl/edo_seq_chk.sv
module edo_seq_chk #(
  parameter logic OE_TIED = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic rsp_err,
  input logic mem_ras_n,
  input logic mem_cas_n,
  input logic mem_we_n,
  input logic mem_oe_n,
  input logic mem_dq_drive
);

  assert_ras_fall_cas_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ras_n) |-> mem_cas_n);

  assert_cas_fall_in_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cas_n) |-> !mem_ras_n);

  assert_drive_only_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_drive |-> !mem_we_n);

  assert_drive_oe_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!OE_TIED && mem_dq_drive) |-> mem_oe_n);

  assert_late_we_oe_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!OE_TIED && $fell(mem_we_n) && !mem_cas_n) |-> mem_oe_n);

  assert_reject_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (mem_ras_n && $past(mem_ras_n)));

  assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ras_n && mem_cas_n && !mem_dq_drive));

  assert_rsp_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

bind edo_seq edo_seq_chk #(.OE_TIED(OE_TIED)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_err      (rsp_err),
  .mem_ras_n    (mem_ras_n),
  .mem_cas_n    (mem_cas_n),
  .mem_we_n     (mem_we_n),
  .mem_oe_n     (mem_oe_n),
  .mem_dq_drive (mem_dq_drive)
);

// File: tb/sim_edo_seq.sv
module edo_mem_model (
  input  logic       clk,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       oe_n,
  input  logic [3:0] addr,
  input  logic [3:0] dq_out,
  input  logic       dq_drive,
  output logic [3:0] dq_in
);
  logic [3:0] mem [256];
  logic [3:0] row_l, col_l, p_addr;
  logic early, p_ras, p_cas, p_we, hold_on, oe_at_we, drive;
  int arun, wrun, crun, hold_run;
  int row_setup, col_setup, we_lead, cas_to_we, ras_hold;
  int contention, cas_low_at_ras, bad_write, ras_falls, float_pulses, we_low_in_row;

  assign drive = !ras_n && !cas_n && !oe_n && we_n && !early;
  assign dq_in = drive ? mem[{row_l, col_l}] : 4'h0;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 4'((i * 7 + 3) & 15);
    row_l = 0; col_l = 0; p_addr = 0; early = 0; p_ras = 1; p_cas = 1; p_we = 1;
    hold_on = 0; oe_at_we = 0; arun = 0; wrun = 0; crun = 0; hold_run = 0;
    row_setup = 0; col_setup = 0; we_lead = 0; cas_to_we = 0; ras_hold = 0;
    contention = 0; cas_low_at_ras = 0; bad_write = 0; ras_falls = 0;
    float_pulses = 0; we_low_in_row = 0;
  end

  always @(negedge clk) begin
    arun = (addr == p_addr) ? arun + 1 : 1;
    wrun = (!we_n && p_we) ? 0 : wrun + 1;
    crun = (!cas_n && p_cas) ? 0 : crun + 1;
    if (drive && dq_drive) contention++;
    if (!ras_n && p_ras) begin
      ras_falls++;
      if (!cas_n) cas_low_at_ras++;
      row_l = addr; row_setup = arun; hold_on = 1; hold_run = 1; we_low_in_row = 0;
    end else if (hold_on) begin
      if (addr == row_l && !ras_n) hold_run++;
      else begin hold_on = 0; ras_hold = hold_run; end
    end
    if (!ras_n && !we_n) we_low_in_row++;
    if (!cas_n && p_cas) begin
      col_l = addr; col_setup = arun;
      if (!we_n) begin
        early = 1; we_lead = wrun;
        if (!dq_drive) bad_write++;
        mem[{row_l, addr}] = dq_out;
      end
    end
    if (cas_n) early = 0;
    if (!we_n && p_we) begin
      if (!cas_n) begin
        cas_to_we = crun; oe_at_we = oe_n;
        if (!dq_drive) bad_write++;
        mem[{row_l, col_l}] = dq_out;
      end else if (ras_n) float_pulses++;
    end
    p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_addr = addr;
  end
endmodule

module sim_edo_seq;
  localparam int T_ASR = 1, T_RAH = 2, T_ASC = 1, T_WCS = 2, T_CAS = 2;
  localparam int T_CAC = 3, T_CWD = 2, T_OD = 2, T_WP = 2, T_RP = 3;

  logic clk, rst_n;
  int total, bad;
  logic [3:0] exp_mem [256];

  logic v0, rdy0, rv0, er0, ras0, cas0, we0, oe0, drv0;
  logic [1:0] k0; logic [7:0] a0; logic [3:0] d0, rd0, ad0, dqo0, dqi0;
  logic v1, rdy1, rv1, er1, ras1, cas1, we1, oe1, drv1;
  logic [1:0] k1; logic [7:0] a1; logic [3:0] d1, rd1, ad1, dqo1, dqi1;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  edo_seq #(.T_ASR(T_ASR), .T_RAH(T_RAH), .T_ASC(T_ASC), .T_WCS(T_WCS), .T_CAS(T_CAS),
            .T_CAC(T_CAC), .T_CWD(T_CWD), .T_OD(T_OD), .T_WP(T_WP), .T_RP(T_RP),
            .OE_TIED(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(v0), .req_ready(rdy0), .req_kind(k0),
    .req_addr(a0), .req_wdata(d0), .rsp_valid(rv0), .rsp_err(er0), .rsp_rdata(rd0),
    .mem_ras_n(ras0), .mem_cas_n(cas0), .mem_we_n(we0), .mem_oe_n(oe0),
    .mem_addr(ad0), .mem_dq_out(dqo0), .mem_dq_drive(drv0), .mem_dq_in(dqi0));

  edo_seq #(.T_ASR(T_ASR), .T_RAH(T_RAH), .T_ASC(T_ASC), .T_WCS(T_WCS), .T_CAS(T_CAS),
            .T_CAC(T_CAC), .T_CWD(T_CWD), .T_OD(T_OD), .T_WP(T_WP), .T_RP(T_RP),
            .OE_TIED(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(v1), .req_ready(rdy1), .req_kind(k1),
    .req_addr(a1), .req_wdata(d1), .rsp_valid(rv1), .rsp_err(er1), .rsp_rdata(rd1),
    .mem_ras_n(ras1), .mem_cas_n(cas1), .mem_we_n(we1), .mem_oe_n(oe1),
    .mem_addr(ad1), .mem_dq_out(dqo1), .mem_dq_drive(drv1), .mem_dq_in(dqi1));

  edo_mem_model m0 (.clk(clk), .ras_n(ras0), .cas_n(cas0), .we_n(we0), .oe_n(oe0),
                    .addr(ad0), .dq_out(dqo0), .dq_drive(drv0), .dq_in(dqi0));
  edo_mem_model m1 (.clk(clk), .ras_n(ras1), .cas_n(cas1), .we_n(we1), .oe_n(oe1),
                    .addr(ad1), .dq_out(dqo1), .dq_drive(drv1), .dq_in(dqi1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_req(input bit inst, input logic [1:0] k, input logic [7:0] a,
                         input logic [3:0] d, output logic [3:0] rd, output logic er);
    int t;
    @(negedge clk);
    t = 0;
    while (!(inst ? rdy1 : rdy0) && t < 100) begin @(negedge clk); t++; end
    if (inst) begin v1 = 1; k1 = k; a1 = a; d1 = d; end
    else      begin v0 = 1; k0 = k; a0 = a; d0 = d; end
    @(negedge clk);
    v0 = 0; v1 = 0;
    t = 0;
    while (!(inst ? rv1 : rv0) && t < 100) begin @(negedge clk); t++; end
    chk(t < 100, "R11 response arrives", t, 0);
    rd = inst ? rd1 : rd0;
    er = inst ? er1 : er0;
    @(negedge clk);
    chk(!(inst ? rv1 : rv0), "R11 single response pulse", int'(inst ? rv1 : rv0), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R11 watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] rd, dw, old;
    logic er;
    int rf;
    total = 0; bad = 0;
    v0 = 0; k0 = 0; a0 = 0; d0 = 0; v1 = 0; k1 = 0; a1 = 0; d1 = 0;
    for (int i = 0; i < 256; i++) exp_mem[i] = 4'((i * 7 + 3) & 15);
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk({ras0, cas0, we0, oe0, drv0, rdy0} == 6'b111101, "R1 reset levels u0",
        {ras0, cas0, we0, oe0, drv0, rdy0}, 6'b111101);
    rst_n = 1;
    @(negedge clk);
    chk({ras0, cas0, we0, oe0, drv0, rdy0} == 6'b111101, "R1 idle levels u0",
        {ras0, cas0, we0, oe0, drv0, rdy0}, 6'b111101);
    chk({ras1, cas1, we1, drv1, rdy1} == 5'b11101, "R1 idle levels u1",
        {ras1, cas1, we1, drv1, rdy1}, 5'b11101);

    // Sweep every address through all four request kinds on the plain build.
    for (int a = 0; a < 256; a++) begin
      logic [7:0] ad;
      ad = 8'(a);
      // R4 early write
      dw = 4'((a + 5) & 15);
      run_req(0, 2'd1, ad, dw, rd, er);
      exp_mem[a] = dw;
      chk(m0.we_lead == T_WCS, "R4 write strobe lead", m0.we_lead, T_WCS);
      chk(m0.row_setup >= T_ASR + 1, "R2 row setup", m0.row_setup, T_ASR + 1);
      chk(m0.col_setup >= T_ASC + 1, "R2 column setup", m0.col_setup, T_ASC + 1);
      if (ad[7:4] != ad[3:0])
        chk(m0.ras_hold == T_RAH, "R2 row hold", m0.ras_hold, T_RAH);
      // R7 read back
      run_req(0, 2'd0, ad, 4'h0, rd, er);
      chk(rd == exp_mem[a], "R7 read after early write R4", rd, exp_mem[a]);
      chk(m0.we_low_in_row == 0, "R7 write strobe stays high", m0.we_low_in_row, 0);
      // R5 late write
      dw = 4'((a * 3 + 1) & 15);
      run_req(0, 2'd2, ad, dw, rd, er);
      exp_mem[a] = dw;
      chk(m0.cas_to_we == T_CWD, "R5 late strobe delay", m0.cas_to_we, T_CWD);
      chk(m0.oe_at_we == 1'b1, "R5 output enable high", int'(m0.oe_at_we), 1);
      run_req(0, 2'd0, ad, 4'h0, rd, er);
      chk(rd == exp_mem[a], "R5 read after late write", rd, exp_mem[a]);
      // R6 read-modify-write
      old = exp_mem[a];
      dw = ~ad[3:0] ^ ad[7:4];
      run_req(0, 2'd3, ad, dw, rd, er);
      exp_mem[a] = dw;
      chk(rd == old, "R6 old data returned", rd, old);
      chk(m0.cas_to_we == T_CAC + T_OD, "R6 turnaround delay", m0.cas_to_we, T_CAC + T_OD);
      chk(m0.oe_at_we == 1'b1, "R6 output enable high", int'(m0.oe_at_we), 1);
      run_req(0, 2'd0, ad, 4'h0, rd, er);
      chk(rd == exp_mem[a], "R6 new data stored", rd, exp_mem[a]);
    end
    chk(m0.contention == 0, "R8 no bus contention u0", m0.contention, 0);
    chk(m0.bad_write == 0, "R8 host drives during writes", m0.bad_write, 0);
    chk(m0.cas_low_at_ras == 0, "R3 column strobe high at row fall", m0.cas_low_at_ras, 0);

    // Output-enable-tied build.
    for (int a = 0; a < 256; a += 17) begin
      logic [7:0] ad;
      ad = 8'(a);
      rf = m1.ras_falls;
      run_req(1, 2'd2, ad, 4'h5, rd, er);
      chk(er == 1'b1, "R9 late write refused", int'(er), 1);
      chk(m1.ras_falls == rf, "R9 no row strobe on refusal", m1.ras_falls, rf);
      run_req(1, 2'd3, ad, 4'h6, rd, er);
      chk(er == 1'b1, "R9 read-modify-write refused", int'(er), 1);
      chk(m1.ras_falls == rf, "R9 no row strobe on refusal rmw", m1.ras_falls, rf);
      dw = 4'((a + 9) & 15);
      run_req(1, 2'd1, ad, dw, rd, er);
      chk(er == 1'b0, "R9 early write accepted", int'(er), 0);
      chk(m1.we_lead == T_WCS, "R4 tied write strobe lead", m1.we_lead, T_WCS);
      rf = m1.float_pulses;
      run_req(1, 2'd0, ad, 4'h0, rd, er);
      chk(rd == dw, "R7 tied read", rd, dw);
      chk(oe1 == 1'b0, "R9 output enable held low", int'(oe1), 0);
      repeat (T_RP + 1) @(negedge clk);
      chk(m1.float_pulses == rf + 1, "R10 float pulse after read", m1.float_pulses, rf + 1);
    end
    chk(m1.contention == 0, "R8 no bus contention u1", m1.contention, 0);
    chk(m1.cas_low_at_ras == 0, "R3 tied column strobe high at row fall", m1.cas_low_at_ras, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule